// File: doc/BRIEF.md
# Receive Byte Queue with Threshold Interrupt

This block buffers the bytes of received radio frames for a host. On the write side it takes one byte per cycle, together with start-of-frame and end-of-frame markers. It also takes accept and reject results from an external frame filter. When the filter is active, the bytes of the frame still under inspection are held in the queue but are not yet valid: they cannot be read and they do not count toward the host's threshold until the filter accepts the frame. A rejected frame is removed by moving the write position back to where that frame began. Any further bytes of that frame are dropped.

On the read side the host pops bytes one at a time and sets a threshold. An interrupt-style flag rises in three cases: when the number of valid bytes is above the threshold, when the last byte of an accepted frame has been stored, or when the queue has overflowed. A byte that arrives while the queue is full causes an overflow. Reception then halts and the flags show a distinctive pattern, with data-available low and the threshold flag high. Valid bytes already stored can still be read. The flush strobe clears both the contents and the error. A read when no valid byte is present produces an underflow pulse. That pulse is not produced when a byte arrives in the same cycle.

Top module: `rx_byte_queue`

## Requirements
- R1: After reset or a `flush` strobe, `data_avail`, `thresh_flag`, `ovf_pulse` and `udf_pulse` are all 0 and no byte is readable.
- R2: Bytes leave in the order they were written. `host_data` presents the popped byte from the clock edge that samples `host_rd` high.
- R3: `data_avail` is 1 exactly when at least one valid byte is stored and the queue is not halted. It follows the internal state one clock later.
- R4: `thresh_flag` is 1 when the count of valid bytes is strictly greater than `host_thresh`. It follows the internal state one clock later.
- R5: With `filt_en` high, the bytes of a frame that has not yet been accepted are neither readable nor counted. They become valid in the cycle `filt_accept` is sampled.
- R6: `filt_reject` on a pending frame discards every byte of that frame already stored. Later bytes of that frame, up to and including its end-of-frame byte, are dropped.
- R7: Storing the end-of-frame byte (`rx_eof` with `rx_valid`) of an accepted frame makes `thresh_flag` 1 even below the threshold. That cause is cleared by the next `host_rd` pulse.
- R8: A byte offered while 128 bytes are stored (valid or pending) gives a one-cycle `ovf_pulse` and halts reception. After that, `data_avail` reads 0 and `thresh_flag` reads 1, and offered bytes are ignored.
- R9: While halted, valid bytes stored before the overflow remain readable in order. Only `flush` leaves the halted state.
- R10: Pending, not-yet-filtered bytes occupy space, so a frame that is never accepted can still cause an overflow.
- R11: `host_rd` with no valid byte stored gives a one-cycle `udf_pulse`. No pulse is given when `rx_valid` is high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empties the queue and clears the overflow halt |
| rx_valid | input | 1 | A received byte is offered this cycle |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Offered byte is the first byte of a frame |
| rx_eof | input | 1 | Offered byte is the last byte of a frame |
| filt_en | input | 1 | Frames wait for a filter decision before their bytes are valid |
| filt_accept | input | 1 | Filter accepts the frame being received |
| filt_reject | input | 1 | Filter rejects the frame being received |
| host_rd | input | 1 | Host pops one byte |
| host_data | output | 8 | Last popped byte |
| host_thresh | input | 7 | Threshold on the count of valid bytes |
| data_avail | output | 1 | At least one valid byte is readable and the queue is not halted |
| thresh_flag | output | 1 | Threshold, end-of-frame or overflow indication |
| ovf_pulse | output | 1 | One-cycle overflow exception |
| udf_pulse | output | 1 | One-cycle underflow exception |

## Verification
The assertions assume well-formed frames. Every frame starts with a byte carrying `rx_sof`, ends with a byte carrying `rx_eof`, and is not restarted in the middle. They also assume the filter gives at most one decision per frame, never both results at once, and no later than the cycle of the end-of-frame byte. The stimulus always separates a pending frame's bytes from its decision, or sends the decision alone in an idle cycle. It starts each scenario from a flush, so the queue position and the frame state are known before the checks begin.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  // Reception state of the frame currently arriving
  typedef enum logic [1:0] {
    FR_IDLE,  // between frames
    FR_PEND,  // stored, waiting for the filter
    FR_KEEP,  // accepted, bytes are valid as they land
    FR_DROP   // rejected, remaining bytes discarded
  } frame_st_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  // Simple dual-port array, synchronous read, no reset on contents
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_ptrs.sv
module rxq_ptrs
  import rxq_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          wr_valid,
  input  logic          wr_sof,
  input  logic          wr_eof,
  input  logic          filt_en,
  input  logic          filt_accept,
  input  logic          filt_reject,
  input  logic          rd_en,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic          re,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] vcount,
  output logic          halted,
  output logic          eof_ev,
  output logic          ovf_q,
  output logic          udf_q
);
  frame_st_e     st_q, st_mid, st_d;
  logic [PW-1:0] wp_q, wp_d;   // next slot to write
  logic [PW-1:0] vp_q, vp_d;   // end of valid region
  logic [PW-1:0] rp_q, rp_d;   // next slot to read
  logic [PW-1:0] fs_q, fs_d;   // start of current frame
  logic          halt_q;
  logic [PW-1:0] used, ready;
  logic          full, wr_want, do_wr, ovf_ev, has_ready, do_rd, udf_ev, keep_eof;

  assign used      = wp_q - rp_q;
  assign ready     = vp_q - rp_q;
  assign full      = (used == PW'(DEPTH));
  assign wr_want   = wr_valid && !halt_q &&
                     (wr_sof || st_q == FR_PEND || st_q == FR_KEEP);
  assign do_wr     = wr_want && !full;
  assign ovf_ev    = wr_want && full;
  assign has_ready = (ready != '0);
  assign do_rd     = rd_en && has_ready;
  assign udf_ev    = rd_en && !has_ready && !wr_valid;

  always_comb begin
    wp_d   = wp_q + PW'(do_wr);
    fs_d   = fs_q;
    st_mid = st_q;
    if (wr_want && wr_sof) begin
      fs_d   = wp_q;
      st_mid = filt_en ? FR_PEND : FR_KEEP;
    end
    if (st_mid == FR_PEND && filt_accept) begin
      st_mid = FR_KEEP;
    end else if (st_mid == FR_PEND && filt_reject) begin
      st_mid = FR_DROP;
      wp_d   = fs_d;
    end
    vp_d     = (st_mid == FR_KEEP) ? wp_d : vp_q;
    keep_eof = do_wr && wr_eof && (st_mid == FR_KEEP);
    st_d     = st_mid;
    if (wr_valid && wr_eof && !halt_q) st_d = FR_IDLE;
    if (ovf_ev) st_d = FR_IDLE;
    rp_d = rp_q + PW'(do_rd);
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp_q   <= '0;
      vp_q   <= '0;
      rp_q   <= '0;
      fs_q   <= '0;
      st_q   <= FR_IDLE;
      halt_q <= 1'b0;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      wp_q   <= wp_d;
      vp_q   <= vp_d;
      rp_q   <= rp_d;
      fs_q   <= fs_d;
      st_q   <= st_d;
      halt_q <= halt_q | ovf_ev;
      ovf_q  <= ovf_ev;
      udf_q  <= udf_ev;
    end
  end

  assign we     = do_wr;
  assign waddr  = wp_q[AW-1:0];
  assign re     = do_rd;
  assign raddr  = rp_q[AW-1:0];
  assign vcount = ready;
  assign halted = halt_q;
  assign eof_ev = keep_eof;

  // R10
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    used <= PW'(DEPTH));

  // R5
  vld_order_chk: assert property (@(posedge clk) disable iff (rst)
    ready <= used);

  // R9
  halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    halt_q && !flush |=> halt_q);
endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int PW = 8,
  parameter int TW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [PW-1:0] vcount,
  input  logic [TW-1:0] thresh,
  input  logic          halted,
  input  logic          eof_ev,
  input  logic          rd_touch,
  output logic          avail,
  output logic          thr
);
  logic hold_q;   // end-of-frame cause, held until the next read access

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hold_q <= 1'b0;
      avail  <= 1'b0;
      thr    <= 1'b0;
    end else begin
      hold_q <= eof_ev | (hold_q & ~rd_touch);
      avail  <= (vcount != '0) && !halted;
      thr    <= halted || (vcount > PW'(thresh)) || hold_q;
    end
  end
endmodule

// File: rtl/rx_byte_queue.sv
module rx_byte_queue #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int TW    = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          rx_valid,
  input  logic [DW-1:0] rx_data,
  input  logic          rx_sof,
  input  logic          rx_eof,
  input  logic          filt_en,
  input  logic          filt_accept,
  input  logic          filt_reject,
  input  logic          host_rd,
  output logic [DW-1:0] host_data,
  input  logic [TW-1:0] host_thresh,
  output logic          data_avail,
  output logic          thresh_flag,
  output logic          ovf_pulse,
  output logic          udf_pulse
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic          we, re, halted, eof_ev;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] vcount;

  rxq_ptrs #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ptrs (
    .clk(clk), .rst(rst), .flush(flush),
    .wr_valid(rx_valid), .wr_sof(rx_sof), .wr_eof(rx_eof),
    .filt_en(filt_en), .filt_accept(filt_accept), .filt_reject(filt_reject),
    .rd_en(host_rd),
    .we(we), .waddr(waddr), .re(re), .raddr(raddr),
    .vcount(vcount), .halted(halted), .eof_ev(eof_ev),
    .ovf_q(ovf_pulse), .udf_q(udf_pulse)
  );

  rxq_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(rx_data),
    .re(re), .raddr(raddr), .rdata(host_data)
  );

  rxq_flags #(.PW(PW), .TW(TW)) u_flags (
    .clk(clk), .rst(rst), .flush(flush),
    .vcount(vcount), .thresh(host_thresh), .halted(halted),
    .eof_ev(eof_ev), .rd_touch(host_rd),
    .avail(data_avail), .thr(thresh_flag)
  );

  // R8
  ovf_sig_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_pulse && !flush |=> thresh_flag && !data_avail);

  // R11
  udf_empty_chk: assert property (@(posedge clk) disable iff (rst)
    udf_pulse |-> !data_avail);
endmodule

// File: tb/sim_rx_byte_queue.sv
`timescale 1ns/1ps
module sim_rx_byte_queue;
  logic       clk = 1'b0;
  logic       rst, flush, rx_valid, rx_sof, rx_eof;
  logic       filt_en, filt_accept, filt_reject, host_rd;
  logic [7:0] rx_data, host_data;
  logic [6:0] host_thresh;
  logic       data_avail, thresh_flag, ovf_pulse, udf_pulse;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  rx_byte_queue u0 (
    .clk(clk), .rst(rst), .flush(flush),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_sof(rx_sof), .rx_eof(rx_eof),
    .filt_en(filt_en), .filt_accept(filt_accept), .filt_reject(filt_reject),
    .host_rd(host_rd), .host_data(host_data), .host_thresh(host_thresh),
    .data_avail(data_avail), .thresh_flag(thresh_flag),
    .ovf_pulse(ovf_pulse), .udf_pulse(udf_pulse)
  );

  // Threshold sweep: {threshold, bytes stored, expected flag}
  localparam logic [15:0] VEC [9] = '{
    {7'd0,   8'd0,   1'b0}, {7'd0,  8'd1,   1'b1}, {7'd3,  8'd3,  1'b0},
    {7'd3,   8'd4,   1'b1}, {7'd10, 8'd20,  1'b1}, {7'd127, 8'd127, 1'b0},
    {7'd126, 8'd127, 1'b1}, {7'd64, 8'd64,  1'b0}, {7'd64, 8'd65, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic do_flush();
    flush = 1'b1; @(negedge clk); flush = 1'b0;
  endtask

  task automatic put(input logic [7:0] d, input logic s, input logic e);
    rx_valid = 1'b1; rx_data = d; rx_sof = s; rx_eof = e;
    @(negedge clk);
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
  endtask

  task automatic pop();
    host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic decide(input logic acc);
    filt_accept = acc; filt_reject = !acc; @(negedge clk);
    filt_accept = 1'b0; filt_reject = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst = 1'b1; flush = 1'b0; rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    rx_data = 8'h00; filt_en = 1'b0; filt_accept = 1'b0; filt_reject = 1'b0;
    host_rd = 1'b0; host_thresh = 7'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle();
    // R1 reset state
    chk("R1", data_avail, 0, "avail after reset");
    chk("R1", thresh_flag, 0, "thr after reset");
    chk("R1", ovf_pulse, 0, "ovf after reset");
    chk("R1", udf_pulse, 0, "udf after reset");

    // R4 / R3 threshold sweep walked from the table
    foreach (VEC[i]) begin
      do_flush();
      filt_en = 1'b0;
      host_thresh = VEC[i][15:9];
      for (int b = 0; b < int'(VEC[i][8:1]); b++) put(8'(b), b == 0, 1'b0);
      idle();
      chk("R4", thresh_flag, int'(VEC[i][0]), $sformatf("thr vec %0d", i));
      chk("R3", data_avail, int'(VEC[i][8:1] != 0), $sformatf("avail vec %0d", i));
    end

    // R2 / R7 order and end-of-frame flag
    do_flush(); host_thresh = 7'd127;
    for (int b = 0; b < 4; b++) put(8'hA0 + 8'(b), b == 0, b == 3);
    idle();
    chk("R7", thresh_flag, 1, "thr after eof");
    chk("R3", data_avail, 1, "avail with frame");
    pop();
    chk("R2", host_data, 8'hA0, "first byte");
    idle();
    chk("R7", thresh_flag, 0, "thr after read");
    for (int b = 1; b < 4; b++) begin
      pop();
      chk("R2", host_data, 8'hA0 + b, "byte order");
    end
    idle();
    chk("R3", data_avail, 0, "avail when drained");

    // R11 underflow and its suppression
    pop();
    chk("R11", udf_pulse, 1, "udf on empty read");
    rx_valid = 1'b1; rx_data = 8'h33; host_rd = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; host_rd = 1'b0;
    chk("R11", udf_pulse, 0, "udf with coincident byte");

    // R5 pending bytes hidden until accept
    do_flush(); filt_en = 1'b1; host_thresh = 7'd0;
    for (int b = 0; b < 3; b++) put(8'hF0 + 8'(b), b == 0, 1'b0);
    idle();
    chk("R5", data_avail, 0, "avail while pending");
    chk("R5", thresh_flag, 0, "thr while pending");
    pop();
    chk("R5", udf_pulse, 1, "pending byte not readable");
    decide(1'b1);
    idle();
    chk("R5", data_avail, 1, "avail after accept");
    chk("R4", thresh_flag, 1, "thr after accept");
    pop();
    chk("R5", host_data, 8'hF0, "first accepted byte");

    // R6 reject rewinds and drops the tail
    do_flush(); filt_en = 1'b1; host_thresh = 7'd127;
    for (int b = 0; b < 3; b++) put(8'hB0 + 8'(b), b == 0, 1'b0);
    decide(1'b0);
    put(8'hB3, 1'b0, 1'b0);
    put(8'hB4, 1'b0, 1'b1);
    put(8'hC0, 1'b1, 1'b0);
    decide(1'b1);
    put(8'hC1, 1'b0, 1'b1);
    idle();
    chk("R6", data_avail, 1, "avail after kept frame");
    pop();
    chk("R6", host_data, 8'hC0, "rejected bytes gone");
    pop();
    chk("R6", host_data, 8'hC1, "second kept byte");
    pop();
    chk("R6", udf_pulse, 1, "only kept bytes stored");

    // R8 / R9 overflow signature, read while halted, flush
    do_flush(); filt_en = 1'b0; host_thresh = 7'd127;
    for (int b = 0; b < 128; b++) put(8'(b) ^ 8'h5A, b == 0, 1'b0);
    idle();
    chk("R4", thresh_flag, 1, "thr at full");
    chk("R8", ovf_pulse, 0, "no ovf at exactly full");
    rx_valid = 1'b1; rx_data = 8'hEE;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R8", ovf_pulse, 1, "ovf pulse");
    idle();
    chk("R8", ovf_pulse, 0, "ovf one cycle");
    chk("R8", data_avail, 0, "avail in overflow");
    chk("R8", thresh_flag, 1, "thr in overflow");
    pop();
    chk("R9", host_data, 8'h5A, "read while halted");
    pop();
    chk("R9", host_data, 8'h5B, "second read while halted");
    put(8'h11, 1'b1, 1'b1);
    idle();
    chk("R9", data_avail, 0, "still halted");
    chk("R9", thresh_flag, 1, "still flagged");
    do_flush();
    idle();
    chk("R9", data_avail, 0, "avail after flush");
    chk("R9", thresh_flag, 0, "thr after flush");

    // R10 pending frame fills the queue
    do_flush(); filt_en = 1'b1; host_thresh = 7'd0;
    for (int b = 0; b < 128; b++) put(8'(b), b == 0, 1'b0);
    idle();
    chk("R10", thresh_flag, 0, "pending not counted");
    rx_valid = 1'b1; rx_data = 8'h77;
    @(negedge clk);
    rx_valid = 1'b0;
    chk("R10", ovf_pulse, 1, "ovf from pending frame");
    idle();
    chk("R10", thresh_flag, 1, "thr after pending ovf");
    chk("R10", data_avail, 0, "avail after pending ovf");
    do_flush();
    idle();
    chk("R1", thresh_flag, 0, "thr after final flush");

    done = 1'b1;
    summary();
    $finish;
  end
endmodule